// File: doc/BRIEF.md
# Pipelined Nearest-Index Merge Tree

This block takes K parallel streams of classification candidates and reduces them to a single stream of winning indices. Each input beat is 64 bits wide: a candidate index sits in the upper half and a non-negative distance sits in the lower half. The n-th beat of every stream together forms one set. For each set the block emits the index whose distance is smallest.

The block is a binary tree of registered pairwise selectors, log2(K) levels deep, with ready/valid handshakes on every edge. Stream 0 feeds the leftmost leaf, and by convention the streams carry ascending index ranges. Each selector prefers its left (lower-numbered) input when the distances are equal. As a result, ties resolve to the lowest stream, which matches a sequential first-minimum scan. The root stage drops the distance and keeps only the 32-bit index.

Top module: `minred_tree`

## Requirements
- R1: While reset is low, and after reset until a set has entered, `m_valid` is 0. With no stream valid, every bit of `s_ready` is 0.
- R2: For every set, `m_idx` equals the index field of the beat with the smallest distance among the K beats of that set.
- R3: When two or more beats of a set share the smallest distance, `m_idx` is the index from the lowest-numbered stream among them.
- R4: The distance is bits [31:0] of a beat and is compared as an unsigned 32-bit value, so 32'h8000_0000 is larger than 32'h7FFF_FFFF. The index is bits [63:32].
- R5: With all streams valid and `m_ready` held high, the first result appears log2(K) cycles after its set is accepted, and later results follow one per cycle.
- R6: `m_last` for a set is the logical AND of the K `s_last` bits of that set.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_idx` and `m_last` hold their values. No result is lost or repeated under back-pressure.
- R8: Sets are formed by beat position within each stream, whatever the arrival skew between streams. A node consumes both of its inputs in the same cycle or neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | NUM_IN*64 | Input beats; stream i occupies bits [i*64 +: 64] |
| s_valid | input | NUM_IN | Per-stream valid |
| s_last | input | NUM_IN | Per-stream end-of-burst marker |
| s_ready | output | NUM_IN | Per-stream ready |
| m_idx | output | 32 | Winning index of the set |
| m_valid | output | 1 | Result valid |
| m_last | output | 1 | AND of the set's end markers |
| m_ready | input | 1 | Result consumer ready |

## Verification
The tree is driven with several distance patterns:
- Distances with one unique minimum that moves from stream to stream. This separates a correct selector from one wired to a fixed branch.
- All distances equal, and minima shared only by the upper streams. These expose a strict-less-than rule or a swapped preference.
- Values on either side of bit 31. These catch a signed comparison.
- A random phase with sparse, skewed valids and a hesitant consumer. This probes the pairing of beats by position and the hold behaviour under stalls.

A full-rate phase measures the latency and the one-per-cycle throughput.

// File: rtl/minred_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the minimum-reduction tree.
// Assumes: index field above distance field inside each beat.
package minred_pkg;
    localparam int DEF_IDX_W  = 32;
    localparam int DEF_DIST_W = 32;

    // Selects what a node register keeps: whole beat, or index only.
    typedef enum logic {
        NODE_FULL  = 1'b0,
        NODE_INDEX = 1'b1
    } node_kind_e;
endpackage

// File: rtl/minred_cmp.sv
`timescale 1ns/1ps
// Pairwise selector: picks the beat with the smaller distance.
// Assumes: distances are non-negative, so an unsigned compare is exact.
// The upper input wins ties, keeping the lower index on equal distance.
module minred_cmp #(
    parameter int IDX_W  = 32,
    parameter int DIST_W = 32,
    localparam int BEAT_W = IDX_W + DIST_W
) (
    input  logic [BEAT_W-1:0] up_beat,
    input  logic [BEAT_W-1:0] lo_beat,
    output logic [BEAT_W-1:0] win_beat
);
    logic [DIST_W-1:0] up_dist;
    logic [DIST_W-1:0] lo_dist;

    // Slice distances and choose the winner, upper branch on ties.
    always_comb begin
        up_dist  = up_beat[DIST_W-1:0];
        lo_dist  = lo_beat[DIST_W-1:0];
        win_beat = (up_dist <= lo_dist) ? up_beat : lo_beat;
    end
endmodule

// File: rtl/minred_node.sv
`timescale 1ns/1ps
// One registered tree node. It joins two child streams, selects the
// nearer candidate and holds the result in an output register.
// Assumes: both children deliver beats of the same set in the same order.
// The register is refilled when it is empty or being drained.
module minred_node
    import minred_pkg::*;
#(
    parameter int         IDX_W  = 32,
    parameter int         DIST_W = 32,
    parameter node_kind_e KIND   = NODE_FULL,
    localparam int BEAT_W = IDX_W + DIST_W,
    localparam int OUT_W  = (KIND == NODE_FULL) ? BEAT_W : IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] up_data,
    input  logic              up_valid,
    input  logic              up_last,
    output logic              up_ready,
    input  logic [BEAT_W-1:0] lo_data,
    input  logic              lo_valid,
    input  logic              lo_last,
    output logic              lo_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);
    logic              room;
    logic              take;
    logic [BEAT_W-1:0] win_beat;
    logic [OUT_W-1:0]  next_out;

    minred_cmp #(
        .IDX_W  (IDX_W),
        .DIST_W (DIST_W)
    ) u_cmp (
        .up_beat  (up_data),
        .lo_beat  (lo_data),
        .win_beat (win_beat)
    );

    // Keep the whole beat for inner nodes, only the index at the root.
    generate
        if (KIND == NODE_FULL) begin : g_full
            assign next_out = win_beat;
        end else begin : g_index
            assign next_out = win_beat[BEAT_W-1:DIST_W];
        end
    endgenerate

    // Joint acceptance: both children move together, only when space exists.
    always_comb begin
        room     = !out_valid || out_ready;
        take     = up_valid && lo_valid && room;
        up_ready = lo_valid && room;
        lo_ready = up_valid && room;
    end

    // Output register: load on acceptance, clear when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= next_out;
            out_last  <= up_last && lo_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
    AST_PAIR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |-> (lo_valid && lo_ready)); // R8
    AST_LAST_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lo_valid && room) |=> (out_last == ($past(up_last) && $past(lo_last)))); // R6
    AST_TIE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lo_valid && room && (up_data[DIST_W-1:0] == lo_data[DIST_W-1:0]))
        |=> (out_data[OUT_W-1 -: IDX_W] == $past(up_data[BEAT_W-1:DIST_W]))); // R3
    AST_UPPER_NEARER: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lo_valid && room && (up_data[DIST_W-1:0] < lo_data[DIST_W-1:0]))
        |=> (out_data[OUT_W-1 -: IDX_W] == $past(up_data[BEAT_W-1:DIST_W]))); // R2
    AST_LOWER_NEARER: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lo_valid && room && (lo_data[DIST_W-1:0] < up_data[DIST_W-1:0]))
        |=> (out_data[OUT_W-1 -: IDX_W] == $past(lo_data[BEAT_W-1:DIST_W]))); // R4
endmodule

// File: rtl/minred_tree.sv
`timescale 1ns/1ps
// Minimum-reduction tree over NUM_IN candidate streams.
// Nodes are numbered as a heap: node n has children 2n and 2n+1, and
// stream i is leaf NUM_IN+i, so stream 0 sits on the leftmost branch.
// Assumes: NUM_IN is a power of two, at least 2.
module minred_tree
    import minred_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DIST_W = DEF_DIST_W,
    localparam int BEAT_W = IDX_W + DIST_W,
    localparam int LEVELS = $clog2(NUM_IN),
    localparam int SLOTS  = 2 * NUM_IN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN*BEAT_W-1:0] s_data,
    input  logic [NUM_IN-1:0]        s_valid,
    input  logic [NUM_IN-1:0]        s_last,
    output logic [NUM_IN-1:0]        s_ready,
    output logic [IDX_W-1:0]         m_idx,
    output logic                     m_valid,
    output logic                     m_last,
    input  logic                     m_ready
);
    // Edges of the tree below the root, by heap slot.
    logic [BEAT_W-1:0] t_data  [2:SLOTS-1];
    logic              t_valid [2:SLOTS-1];
    logic              t_last  [2:SLOTS-1];
    logic              t_ready [2:SLOTS-1];

    // Leaves: attach the input streams in ascending order.
    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_leaf
            assign t_data[NUM_IN+i]  = s_data[i*BEAT_W +: BEAT_W];
            assign t_valid[NUM_IN+i] = s_valid[i];
            assign t_last[NUM_IN+i]  = s_last[i];
            assign s_ready[i]        = t_ready[NUM_IN+i];
        end
    endgenerate

    // Internal nodes: the root keeps only the index, the others the whole beat.
    generate
        for (genvar n = 1; n < NUM_IN; n++) begin : g_node
            if (n == 1) begin : g_root
                minred_node #(
                    .IDX_W  (IDX_W),
                    .DIST_W (DIST_W),
                    .KIND   (NODE_INDEX)
                ) u_node (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .up_data   (t_data[2]),
                    .up_valid  (t_valid[2]),
                    .up_last   (t_last[2]),
                    .up_ready  (t_ready[2]),
                    .lo_data   (t_data[3]),
                    .lo_valid  (t_valid[3]),
                    .lo_last   (t_last[3]),
                    .lo_ready  (t_ready[3]),
                    .out_data  (m_idx),
                    .out_valid (m_valid),
                    .out_last  (m_last),
                    .out_ready (m_ready)
                );
            end else begin : g_inner
                minred_node #(
                    .IDX_W  (IDX_W),
                    .DIST_W (DIST_W),
                    .KIND   (NODE_FULL)
                ) u_node (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .up_data   (t_data[2*n]),
                    .up_valid  (t_valid[2*n]),
                    .up_last   (t_last[2*n]),
                    .up_ready  (t_ready[2*n]),
                    .lo_data   (t_data[2*n+1]),
                    .lo_valid  (t_valid[2*n+1]),
                    .lo_last   (t_last[2*n+1]),
                    .lo_ready  (t_ready[2*n+1]),
                    .out_data  (t_data[n]),
                    .out_valid (t_valid[n]),
                    .out_last  (t_last[n]),
                    .out_ready (t_ready[n])
                );
            end
        end
    endgenerate

    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid == '0) |-> (s_ready == '0)); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_idx) && $stable(m_last))); // R7

    // Depth sanity for the elaborated configuration (documentation aid).
    localparam int DEPTH_CHECK = LEVELS;
    if (DEPTH_CHECK < 1) begin : g_bad_depth
        $error("minred_tree needs at least two inputs");
    end
endmodule

// File: tb/minred_tree_bench.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference: queued stimulus,
// first-minimum scan per set, and a comparison on every clock.
module minred_tree_bench;
    localparam int K   = 4;
    localparam int LVL = 2;
    localparam int BW  = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [K*BW-1:0] s_data;
    logic [K-1:0]    s_valid;
    logic [K-1:0]    s_last;
    logic [K-1:0]    s_ready;
    logic [31:0]     m_idx;
    logic            m_valid;
    logic            m_last;
    logic            m_ready;

    always #2 clk = ~clk;

    minred_tree #(.NUM_IN(K)) u_minred_tree (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .m_idx(m_idx), .m_valid(m_valid),
        .m_last(m_last), .m_ready(m_ready)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [64:0] sq [K][$];
    logic [32:0] eq [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dist_of(int mode, int j, int i);
        case (mode)
            0: return 32'((j * 7 + i * 13) % 11) * 3 + 32'(i);
            1: return 32'd100;
            2: return (i >= (j % K)) ? 32'd10 : 32'd20 + 32'(i);
            3: return (i == (j % K)) ? 32'h7FFF_FFFF : 32'h8000_0000 + 32'(i);
            default: return {$urandom_range(3), 30'($urandom_range(7))};
        endcase
    endfunction

    // Fill stream queues and compute the expected results by a linear scan.
    task automatic fill(int nsets, int mode);
        for (int j = 0; j < nsets; j++) begin
            logic [31:0] d [K];
            logic [31:0] id [K];
            logic        l [K];
            int          best;
            logic        all_l;
            for (int i = 0; i < K; i++) begin
                d[i]  = dist_of(mode, j, i);
                id[i] = 32'hC100_0000 | (32'(j) << 8) | 32'(i);
                l[i]  = (mode == 4) ? 1'($urandom_range(1))
                                    : (((j * 5 + i) % 3 == 0) || (j % 4 == 3));
                sq[i].push_back({l[i], id[i], d[i]});
            end
            best  = 0;
            all_l = l[0];
            for (int i = 1; i < K; i++) begin
                if (d[i] < d[best]) best = i;
                all_l = all_l & l[i];
            end
            eq.push_back({all_l, id[best]});
        end
    endtask

    task automatic run_phase(int nsets, int mode, int vd, int rd, string tag, bit lat);
        logic [K-1:0] hs;
        bit   p_stall;
        logic [31:0] p_idx;
        logic p_last;
        int   cyc, t_in, t_out0, t_outn, got;
        bit   busy;
        fill(nsets, mode);
        hs = '0; p_stall = 0; p_idx = '0; p_last = 0;
        cyc = 0; t_in = -1; t_out0 = -1; t_outn = -1; got = 0;
        busy = 1;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            for (int i = 0; i < K; i++) begin
                if (hs[i]) begin
                    void'(sq[i].pop_front());
                    s_valid[i] = 1'b0;
                end
                if (!s_valid[i] && sq[i].size() > 0 && $urandom_range(99) < vd) begin
                    s_valid[i] = 1'b1;
                    s_data[i*BW +: BW] = sq[i][0][63:0];
                    s_last[i] = sq[i][0][64];
                end
            end
            m_ready = ($urandom_range(99) < rd);
            #1;
            if (p_stall) begin
                check(m_valid && m_idx == p_idx && m_last == p_last, "R7",
                      "stalled output changed", {31'b0, m_last, m_idx}, {31'b0, p_last, p_idx});
            end
            for (int i = 0; i < K; i++) hs[i] = s_valid[i] && s_ready[i];
            if (hs[0] && t_in < 0) t_in = cyc;
            if (m_valid && m_ready) begin
                if (t_out0 < 0) t_out0 = cyc;
                t_outn = cyc;
                if (eq.size() == 0) begin
                    check(0, "R7", "extra result", {32'b0, m_idx}, 64'b0);
                end else begin
                    logic [32:0] e;
                    e = eq.pop_front();
                    check(m_idx == e[31:0], tag, $sformatf("index of set %0d", got),
                          {32'b0, m_idx}, {32'b0, e[31:0]});
                    check(m_last == e[32], "R6", $sformatf("end marker of set %0d", got),
                          {63'b0, m_last}, {63'b0, e[32]});
                end
                got++;
            end
            p_stall = m_valid && !m_ready;
            p_idx = m_idx;
            p_last = m_last;
            cyc++;
            busy = (eq.size() > 0);
            for (int i = 0; i < K; i++) if (sq[i].size() > 0) busy = 1;
        end
        if (busy) begin
            check(0, tag, "phase timed out, results outstanding", 64'(eq.size()), 64'b0);
            eq.delete();
            for (int i = 0; i < K; i++) sq[i].delete();
        end
        @(negedge clk);
        s_valid = '0;
        if (lat) begin
            check(t_out0 - t_in == LVL, "R5", "latency in cycles", 64'(t_out0 - t_in), 64'(LVL));
            check(t_outn - t_out0 == nsets - 1, "R5", "cycles spanned by results",
                  64'(t_outn - t_out0), 64'(nsets - 1));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; s_valid = '0; s_last = '0; s_data = '0; m_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(m_valid == 1'b0, "R1", "valid during reset", {63'b0, m_valid}, 64'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(m_valid == 1'b0, "R1", "valid after reset", {63'b0, m_valid}, 64'b0);
        check(s_ready == '0, "R1", "ready with no input valid", {60'b0, s_ready}, 64'b0);

        run_phase(20, 0, 100, 100, "R2", 1);  // R5 full rate, moving minimum
        run_phase(12, 1, 100, 100, "R3", 0);  // all distances equal
        run_phase(12, 2, 80, 90, "R3", 0);    // minimum shared by upper streams
        run_phase(12, 3, 100, 70, "R4", 0);   // values around bit 31
        run_phase(60, 4, 35, 50, "R8", 0);    // skewed valids, stalls (R7)
        run_phase(30, 0, 60, 30, "R2", 0);    // moving minimum under back-pressure

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule